// File: doc/BRIEF.md
# Local Interrupt Selector

This block decides, in every cycle, whether a hart should take one of its local interrupts and which one. Each interrupt that is both pending and enabled becomes a candidate. The delegation mask sends each candidate to either the machine path or the supervisor path. Each path is then gated by its own enable rule, which depends on the current privilege level and on that level's global enable bit.

Among the candidates that survive, the one with the lowest index is chosen. The block reports a take strobe, the chosen interrupt number, and a trap cause word. The cause word is the number with a flag bit set in its most significant position.

The decision logic is combinational. By default it is followed by one register stage, so the outputs follow the inputs of the previous clock edge; a parameter removes that stage. Privilege is encoded on two bits: user = 0, supervisor = 1, reserved = 2, machine = 3.

Top module: `irq_selector`

## Requirements
- R1: An interrupt is a candidate only when its bit is set in both `pend_i` and `en_i`. A bit pending without its enable is never chosen.
- R2: A candidate whose `deleg_i` bit is 0 is taken when `priv_i` is not 3 (machine), or when `priv_i` is 3 and `m_gie_i` is 1. In machine mode with `m_gie_i` = 0 it is blocked.
- R3: A candidate whose `deleg_i` bit is 1 is taken in user mode (`priv_i` = 0) whatever `s_gie_i` is. In supervisor mode (`priv_i` = 1) it is taken only when `s_gie_i` = 1. In machine mode it is never taken.
- R4: The reserved privilege code 2 counts as above supervisor and below machine. Non-delegated candidates pass regardless of `m_gie_i`, and delegated candidates are blocked.
- R5: When several candidates survive their gates, `num_o` is the lowest surviving index. A lower-index candidate that is blocked by its own path does not hide a higher-index one that survives.
- R6: When no candidate survives, `take_o` = 0, `num_o` = 0 and `cause_o` = 0.
- R7: When `take_o` = 1, `cause_o` bit CAUSE_W-1 is 1, `cause_o[IDXW-1:0]` equals `num_o`, and every other bit is 0.
- R8: With `REG_OUT` = 1 (default), the outputs sampled after a rising clock edge reflect the inputs present at that edge. Each edge produces an independent decision.
- R9: While `rst_n` is low, `take_o`, `num_o` and `cause_o` are 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | W | Pending interrupt bits |
| en_i | input | W | Per-interrupt enable bits |
| deleg_i | input | W | Delegation mask, 1 sends a bit to the supervisor path |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 2 reserved, 3 machine |
| m_gie_i | input | 1 | Global machine interrupt enable |
| s_gie_i | input | 1 | Global supervisor interrupt enable |
| take_o | output | 1 | An interrupt should be taken |
| num_o | output | $clog2(W) | Chosen interrupt number, 0 when none |
| cause_o | output | CAUSE_W | Cause word: flag in the top bit OR'd with the number |

## Verification
The bound checker keeps a copy of the inputs aligned with the output stage. On every cycle it checks four things against that copy: the chosen bit was pending and enabled, its path's enable rule held, no lower surviving bit existed, and a silent output really meant an empty surviving set. It also checks the shape of the cause word and the all-zero idle outputs. Some behaviours are only shown by the bench's directed scenarios, because the properties accept any legal result. These are the user-mode versus supervisor-mode contrast for delegated interrupts, the handling of the reserved privilege code, the reset values, and the one-edge latency.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // Machine path: open below machine level, or at machine level with its global enable.
  function automatic logic mach_path_open(input priv_e lvl, input logic gie);
    return (lvl != PRIV_MACH) || gie;
  endfunction

  // Supervisor path: open at user level, or at supervisor level with its global enable.
  function automatic logic super_path_open(input priv_e lvl, input logic gie);
    return (lvl == PRIV_USER) || ((lvl == PRIV_SUPER) && gie);
  endfunction

endpackage

// File: rtl/irqsel_gate.sv
module irqsel_gate
  import irqsel_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] deleg_i,
  input  logic [1:0]   priv_i,
  input  logic         m_gie_i,
  input  logic         s_gie_i,
  output logic [W-1:0] survive_o
);

  priv_e        lvl;
  logic         m_open;
  logic         s_open;
  logic [W-1:0] cand;
  logic [W-1:0] m_side;
  logic [W-1:0] s_side;

  always_comb begin
    lvl    = priv_e'(priv_i);
    m_open = mach_path_open(lvl, m_gie_i);
    s_open = super_path_open(lvl, s_gie_i);
    cand   = pend_i & en_i;
    m_side = cand & ~deleg_i & {W{m_open}};
    s_side = cand &  deleg_i & {W{s_open}};
    survive_o = m_side | s_side;
  end

endmodule

// File: rtl/irqsel_lsb.sv
module irqsel_lsb #(
  parameter int W    = 64,
  parameter int IDXW = $clog2(W)
) (
  input  logic [W-1:0]    vec_i,
  output logic            hit_o,
  output logic [IDXW-1:0] idx_o
);

  logic [W-1:0] lowest;

  always_comb begin
    lowest = vec_i & (~vec_i + W'(1));
    hit_o  = |vec_i;
  end

  // Each index bit is the OR of the one-hot positions whose index has that bit set.
  for (genvar b = 0; b < IDXW; b++) begin : g_idx_bit
    always_comb begin
      idx_o[b] = 1'b0;
      for (int i = 0; i < W; i++) begin
        if (((i >> b) & 1) == 1) idx_o[b] = idx_o[b] | lowest[i];
      end
    end
  end

endmodule

// File: rtl/irqsel_stage.sv
module irqsel_stage #(
  parameter int  IDXW    = 6,
  parameter int  CAUSE_W = 64,
  parameter bit  REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_i,
  input  logic [IDXW-1:0]    idx_i,
  output logic               take_o,
  output logic [IDXW-1:0]    num_o,
  output logic [CAUSE_W-1:0] cause_o
);

  localparam logic [CAUSE_W-1:0] FLAG = {1'b1, {(CAUSE_W-1){1'b0}}};

  logic               nxt_take;
  logic [IDXW-1:0]    nxt_num;
  logic [CAUSE_W-1:0] nxt_cause;

  always_comb begin
    nxt_take  = hit_i;
    nxt_num   = hit_i ? idx_i : '0;
    nxt_cause = hit_i ? (FLAG | CAUSE_W'(idx_i)) : '0;
  end

  if (REG_OUT) begin : g_reg
    logic               q_take;
    logic [IDXW-1:0]    q_num;
    logic [CAUSE_W-1:0] q_cause;
    logic               upd_en;

    always_comb begin
      upd_en = (nxt_take != q_take) || (nxt_num != q_num);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_take  <= 1'b0;
        q_num   <= '0;
        q_cause <= '0;
      end else if (upd_en) begin
        q_take  <= nxt_take;
        q_num   <= nxt_num;
        q_cause <= nxt_cause;
      end
    end

    always_comb begin
      take_o  = q_take;
      num_o   = q_num;
      cause_o = q_cause;
    end
  end else begin : g_comb
    always_comb begin
      take_o  = nxt_take;
      num_o   = nxt_num;
      cause_o = nxt_cause;
    end
  end

endmodule

// File: rtl/irq_selector.sv
module irq_selector #(
  parameter int W       = 64,
  parameter int CAUSE_W = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int IDXW   = $clog2(W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       pend_i,
  input  logic [W-1:0]       en_i,
  input  logic [W-1:0]       deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic               take_o,
  output logic [IDXW-1:0]    num_o,
  output logic [CAUSE_W-1:0] cause_o
);

  logic [W-1:0]    survive;
  logic            hit;
  logic [IDXW-1:0] idx;

  irqsel_gate #(.W(W)) u_gate (
    .pend_i   (pend_i),
    .en_i     (en_i),
    .deleg_i  (deleg_i),
    .priv_i   (priv_i),
    .m_gie_i  (m_gie_i),
    .s_gie_i  (s_gie_i),
    .survive_o(survive)
  );

  irqsel_lsb #(.W(W), .IDXW(IDXW)) u_lsb (
    .vec_i(survive),
    .hit_o(hit),
    .idx_o(idx)
  );

  irqsel_stage #(.IDXW(IDXW), .CAUSE_W(CAUSE_W), .REG_OUT(REG_OUT)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit),
    .idx_i  (idx),
    .take_o (take_o),
    .num_o  (num_o),
    .cause_o(cause_o)
  );

endmodule

// File: rtl/irq_selector_chk.sv
module irq_selector_chk #(
  parameter int W       = 64,
  parameter int CAUSE_W = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int IDXW   = $clog2(W)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [W-1:0]       pend_i,
  input logic [W-1:0]       en_i,
  input logic [W-1:0]       deleg_i,
  input logic [1:0]         priv_i,
  input logic               m_gie_i,
  input logic               s_gie_i,
  input logic               take_o,
  input logic [IDXW-1:0]    num_o,
  input logic [CAUSE_W-1:0] cause_o
);

  logic [W-1:0] s_pend, s_en, s_deleg;
  logic [1:0]   s_priv;
  logic         s_mgie, s_sgie;
  logic         m_ok, s_ok;
  logic [W-1:0] alive;
  logic [W-1:0] below;

  if (REG_OUT) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_pend <= '0; s_en <= '0; s_deleg <= '0;
        s_priv <= '0; s_mgie <= 1'b0; s_sgie <= 1'b0;
      end else begin
        s_pend <= pend_i; s_en <= en_i; s_deleg <= deleg_i;
        s_priv <= priv_i; s_mgie <= m_gie_i; s_sgie <= s_gie_i;
      end
    end
  end else begin : g_direct
    always_comb begin
      s_pend = pend_i; s_en = en_i; s_deleg = deleg_i;
      s_priv = priv_i; s_mgie = m_gie_i; s_sgie = s_gie_i;
    end
  end

  always_comb begin
    m_ok  = (s_priv != 2'd3) || s_mgie;
    s_ok  = (s_priv == 2'd0) || ((s_priv == 2'd1) && s_sgie);
    alive = s_pend & s_en & ((s_deleg & {W{s_ok}}) | (~s_deleg & {W{m_ok}}));
    below = (W'(1) << num_o) - W'(1);
  end

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (num_o == '0) && (cause_o == '0));

  assert_empty_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (alive == '0));

  assert_cause_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> cause_o[CAUSE_W-1] && (cause_o[IDXW-1:0] == num_o)
               && (cause_o[CAUSE_W-2:IDXW] == '0));

  assert_candidate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> s_pend[num_o] && s_en[num_o]);

  assert_mach_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !s_deleg[num_o]) |-> ((s_priv != 2'd3) || s_mgie));

  assert_super_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && s_deleg[num_o]) |-> ((s_priv == 2'd0) || ((s_priv == 2'd1) && s_sgie)));

  assert_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((alive & below) == '0));

endmodule

bind irq_selector irq_selector_chk #(
  .W(W), .CAUSE_W(CAUSE_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .deleg_i(deleg_i),
  .priv_i(priv_i), .m_gie_i(m_gie_i), .s_gie_i(s_gie_i),
  .take_o(take_o), .num_o(num_o), .cause_o(cause_o)
);

// File: tb/test_irq_selector.sv
`timescale 1ns/1ps
module test_irq_selector;

  localparam int W  = 64;
  localparam int IW = 6;
  localparam int CW = 64;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  pend, en, deleg;
  logic [1:0]    priv;
  logic          mgie, sgie;
  logic          take;
  logic [IW-1:0] num;
  logic [CW-1:0] cause;

  int    total = 0;
  int    failed = 0;
  bit    armed = 0;
  string cur_tag = "R9";

  logic          exp_take;
  int            exp_num;
  logic [CW-1:0] exp_cause;

  irq_selector i_irq_selector (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .m_gie_i(mgie), .s_gie_i(sgie),
    .take_o(take), .num_o(num), .cause_o(cause)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference: scan upward, first bit that passes its path wins.
  task automatic model();
    bit m_ok, s_ok;
    m_ok = (priv != 2'd3) || mgie;
    s_ok = (priv == 2'd0) || (priv == 2'd1 && sgie);
    exp_take = 1'b0; exp_num = 0; exp_cause = '0;
    if (!rst_n) return;
    for (int i = 0; i < W; i++) begin
      if (pend[i] && en[i] && (deleg[i] ? s_ok : m_ok)) begin
        exp_take  = 1'b1;
        exp_num   = i;
        exp_cause = (64'h1 << 63) | 64'(i);
        break;
      end
    end
  endtask

  task automatic compare();
    total++;
    if (take !== exp_take || int'(num) != exp_num || cause !== exp_cause) begin
      failed++;
      $display("FAIL %s: take=%0b num=%0d cause=%h expected take=%0b num=%0d cause=%h",
               cur_tag, take, num, cause, exp_take, exp_num, exp_cause);
    end
  endtask

  task automatic step(input logic [W-1:0] p, input logic [W-1:0] e, input logic [W-1:0] d,
                      input logic [1:0] pr, input logic m, input logic s, input string tag);
    @(negedge clk);
    if (armed) compare();
    armed = 1;
    pend = p; en = e; deleg = d; priv = pr; mgie = m; sgie = s;
    model();
    cur_tag = tag;
  endtask

  function automatic logic [W-1:0] bitv(input int i);
    return 64'h1 << i;
  endfunction

  initial begin
    #100000;
    total++; failed++;
    $display("FAIL watchdog expired in scenario %s", cur_tag);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pend = '0; en = '0; deleg = '0; priv = 2'd3; mgie = 1'b0; sgie = 1'b0;
    // R9: outputs held at zero in reset despite live candidates
    step('1, '1, '0, 2'd3, 1'b1, 1'b1, "R9");
    step('1, '1, '0, 2'd0, 1'b1, 1'b1, "R9");
    step(bitv(4), bitv(4), '0, 2'd3, 1'b1, 1'b1, "R9");
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    model();
    cur_tag = "R9";
    // R6: nothing pending
    step('0, '1, '0, 2'd3, 1'b1, 1'b1, "R6");
    // R1: pending without enable is ignored
    step(bitv(5) | bitv(9), bitv(9), '0, 2'd3, 1'b1, 1'b0, "R1");
    step(bitv(5), bitv(6), '0, 2'd0, 1'b1, 1'b1, "R1");
    // R2: machine path
    step(bitv(3), bitv(3), '0, 2'd3, 1'b0, 1'b1, "R2");
    step(bitv(3), bitv(3), '0, 2'd3, 1'b1, 1'b0, "R2");
    step(bitv(3), bitv(3), '0, 2'd1, 1'b0, 1'b0, "R2");
    step(bitv(3), bitv(3), '0, 2'd0, 1'b0, 1'b0, "R2");
    // R3: delegated path
    step(bitv(7), bitv(7), bitv(7), 2'd1, 1'b1, 1'b0, "R3");
    step(bitv(7), bitv(7), bitv(7), 2'd1, 1'b1, 1'b1, "R3");
    step(bitv(7), bitv(7), bitv(7), 2'd0, 1'b0, 1'b0, "R3");
    step(bitv(7), bitv(7), bitv(7), 2'd3, 1'b1, 1'b1, "R3");
    // R4: reserved privilege code
    step(bitv(4), bitv(4), '0, 2'd2, 1'b0, 1'b1, "R4");
    step(bitv(2), bitv(2), bitv(2), 2'd2, 1'b1, 1'b1, "R4");
    // R5: lowest surviving index, blocked low bit does not hide
    step(bitv(1) | bitv(6), '1, bitv(1), 2'd1, 1'b1, 1'b0, "R5");
    step(bitv(62) | bitv(63), '1, '0, 2'd0, 1'b0, 1'b0, "R5");
    // R7: highest index yields full-width cause
    step(bitv(63), bitv(63), '0, 2'd3, 1'b1, 1'b0, "R7");
    step(bitv(0), bitv(0), bitv(0), 2'd0, 1'b0, 1'b0, "R7");
    // R8: back-to-back changing decisions, one per edge
    step(bitv(10), '1, '0, 2'd3, 1'b1, 1'b0, "R8");
    step('0, '1, '0, 2'd3, 1'b1, 1'b0, "R8");
    step(bitv(20), '1, '0, 2'd3, 1'b1, 1'b0, "R8");
    step(bitv(11), '1, '0, 2'd3, 1'b1, 1'b0, "R8");
    // R5: random mixes, dense and sparse
    for (int k = 0; k < 200; k++) begin
      logic [W-1:0] p, e, d;
      p = {$urandom, $urandom};
      e = {$urandom, $urandom};
      d = {$urandom, $urandom};
      if (k % 2 == 1) p = p & {$urandom, $urandom} & {$urandom, $urandom};
      step(p, e, d, 2'($urandom), 1'($urandom), 1'($urandom), "R5");
    end
    step('0, '0, '0, 2'd3, 1'b0, 1'b0, "R6");
    @(negedge clk);
    compare();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule